// File: doc/BRIEF.md
# DMA Channel Arm and Control Register

This block holds the control and status bits for each channel of a small two-channel DMA controller. It sits between a CPU-side register port and an external transfer engine. Each channel has an 8-bit register with two live bits: an enable flag and a transfer-pending flag. The CPU can write a whole byte or set or clear one chosen bit. The block uses these flags to decide when a trigger may start a transfer.

A channel is armed when both of its flags are set. While armed, it accepts a software trigger, or the one hardware trigger chosen by its 3-bit source-select field. When it accepts a trigger, it sends a one-cycle start strobe to the engine. It then waits for the engine to report done.

On normal completion the pending flag clears and a one-cycle interrupt fires. If software clears the pending flag during a transfer, the block sends a one-cycle abort strobe and fires no interrupt. The enable flag cannot be written while the pending flag is set. Because of this, every write is checked against the state the channel is in at that moment.

Top module: `dma_arm_ctrl`

## Requirements
- R1: In each channel register, bit 7 is the enable flag and bit 0 is the pending flag. Bits 6 to 1 always read as 0. A read at an address that matches no channel returns 00h.
- R2: After reset, both registers read 00h and all strobe, interrupt and clock-enable outputs are low.
- R3: The write type is chosen by `wr_bitmode`.
  - When it is 0, a write loads both flags from `wr_data`.
  - When it is 1, the value on `wr_bitval` goes into the bit numbered by `wr_bitsel`. A bit write to any of bits 6 to 1 changes nothing.
- R4: While a channel's pending flag is 1, any write to its enable flag is ignored. The pending flag in the same write still takes effect.
- R5: A trigger is accepted only when enable=1, pending=1 and no transfer is in progress. Triggers in any other state are dropped, and a CPU write to the pending bit in the same cycle takes priority.
- R6: An accepted trigger produces exactly one start pulse, in the cycle after it arrives.
  - The trigger can be the channel's software trigger, or `hw_trig[src_sel]` using that channel's 3-bit field.
  - Either trigger alone is enough; a hardware line that is not selected has no effect.
- R7: When a transfer is in progress and the engine reports done, the pending flag clears and a one-cycle completion interrupt fires.
- R8: Writing 0 to the pending flag during a transfer sends one abort pulse, clears the flag and fires no interrupt. Clearing a pending flag that has no transfer in progress sends no abort.
- R9: The clock-enable output of each channel equals its enable flag.
- R10: Channel 0 is at byte address `BASE_ADDR` and channel 1 at `BASE_ADDR+1`. Writes and triggers for one channel never change the other channel.
- R11: While a transfer is in progress, further triggers are ignored until the pending flag clears.
- R12: If a pending-flag write and an engine done arrive in the same cycle, the pending flag ends at 0 and only the completion interrupt fires, with no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_bitmode | input | 1 | 0 = byte write, 1 = single-bit write |
| wr_bitsel | input | 3 | Bit number for a single-bit write |
| wr_bitval | input | 1 | Value for a single-bit write |
| wr_data | input | 8 | Data for a byte write |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 8 | Readback of the addressed register |
| sw_trig | input | NCH | Software trigger, one bit per channel |
| hw_trig | input | 2**SRC_W | Hardware trigger sources |
| src_sel | input | NCH*SRC_W | Source-select field for each channel |
| eng_start | output | NCH | One-cycle start strobe to the engine |
| eng_abort | output | NCH | One-cycle forced-termination strobe |
| eng_done | input | NCH | Completion report from the engine |
| clk_en | output | NCH | Channel clock enable |
| irq_done | output | NCH | One-cycle completion interrupt |

## Verification
The assertions check these rules on every cycle:
- A start strobe only ever comes from an armed channel.
- Start and interrupt strobes last one cycle.
- An interrupt never comes with a set pending flag or with an abort.
- The enable flag never moves while the pending flag was set.

The bench scenarios show what a property cannot easily relate:
- The cycle in which each strobe appears.
- That unselected sources and triggers in a busy or unarmed channel are dropped.
- That a pending-flag clear with no transfer in progress sends no abort.
- How a write and a completion that collide are resolved.

// File: rtl/dma_arm_pkg.sv
package dma_arm_pkg;
   localparam int REG_W    = 8;
   localparam int BSEL_W   = $clog2(REG_W);
   localparam int EN_BIT   = 7;
   localparam int PEND_BIT = 0;

   // one decoded CPU write as seen by a single channel
   typedef struct packed {
      logic hit;
      logic set_en;
      logic en_val;
      logic set_pend;
      logic pend_val;
   } chan_wr_t;
endpackage

// File: rtl/dma_arm_wrdec.sv
module dma_arm_wrdec
   import dma_arm_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int MY_ADDR = 12
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_bitmode,
   input  logic [BSEL_W-1:0] wr_bitsel,
   input  logic              wr_bitval,
   input  logic [REG_W-1:0]  wr_data,
   output chan_wr_t          req
);
   always_comb begin
      req.hit = wr_en && (wr_addr == ADDR_W'(MY_ADDR));
      if (wr_bitmode) begin
         req.set_en   = (wr_bitsel == BSEL_W'(EN_BIT));
         req.en_val   = wr_bitval;
         req.set_pend = (wr_bitsel == BSEL_W'(PEND_BIT));
         req.pend_val = wr_bitval;
      end else begin
         req.set_en   = 1'b1;
         req.en_val   = wr_data[EN_BIT];
         req.set_pend = 1'b1;
         req.pend_val = wr_data[PEND_BIT];
      end
   end
endmodule

// File: rtl/dma_arm_trigq.sv
module dma_arm_trigq #(
   parameter int SRC_W     = 3,
   parameter int TRIG_EDGE = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sw_trig,
   input  logic [(1<<SRC_W)-1:0] hw_trig,
   input  logic [SRC_W-1:0]      src_sel,
   output logic                  trig
);
   localparam int NSRC = 1 << SRC_W;

   generate
      if (TRIG_EDGE != 0) begin : g_edge
         logic [NSRC-1:0] hw_prev_q;
         logic [NSRC-1:0] hw_rise;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hw_prev_q <= '0;
            else        hw_prev_q <= hw_trig;
         end
         assign hw_rise = hw_trig & ~hw_prev_q;
         assign trig    = sw_trig | hw_rise[src_sel];
      end else begin : g_level
         assign trig = sw_trig | hw_trig[src_sel];
      end
   endgenerate
endmodule

// File: rtl/dma_arm_chan.sv
module dma_arm_chan
   import dma_arm_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  chan_wr_t req,
   input  logic     trig,
   input  logic     done,
   output logic     en,
   output logic     pend,
   output logic     start,
   output logic     abort,
   output logic     irq
);
   logic en_q, pend_q, busy_q, start_q, abort_q, irq_q;

   // enable flag: writable only while nothing is pending
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= 1'b0;
      else if (req.hit && req.set_en && !pend_q)
         en_q <= req.en_val;
   end

   // pending flag, transfer tracking and strobes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         abort_q <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         start_q <= 1'b0;
         abort_q <= 1'b0;
         irq_q   <= 1'b0;
         if (busy_q && done) begin
            pend_q <= 1'b0;
            busy_q <= 1'b0;
            irq_q  <= 1'b1;
         end else if (req.hit && req.set_pend) begin
            pend_q <= req.pend_val;
            if (busy_q && !req.pend_val) begin
               busy_q  <= 1'b0;
               abort_q <= 1'b1;
            end
         end else if (en_q && pend_q && !busy_q && trig) begin
            busy_q  <= 1'b1;
            start_q <= 1'b1;
         end
      end
   end

   assign en    = en_q;
   assign pend  = pend_q;
   assign start = start_q;
   assign abort = abort_q;
   assign irq   = irq_q;
endmodule

// File: rtl/dma_arm_ctrl.sv
module dma_arm_ctrl
   import dma_arm_pkg::*;
#(
   parameter int NCH       = 2,
   parameter int ADDR_W    = 4,
   parameter int BASE_ADDR = 12,
   parameter int SRC_W     = 3,
   parameter int TRIG_EDGE = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic                  wr_bitmode,
   input  logic [BSEL_W-1:0]     wr_bitsel,
   input  logic                  wr_bitval,
   input  logic [REG_W-1:0]      wr_data,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [REG_W-1:0]      rd_data,
   input  logic [NCH-1:0]        sw_trig,
   input  logic [(1<<SRC_W)-1:0] hw_trig,
   input  logic [NCH*SRC_W-1:0]  src_sel,
   output logic [NCH-1:0]        eng_start,
   output logic [NCH-1:0]        eng_abort,
   input  logic [NCH-1:0]        eng_done,
   output logic [NCH-1:0]        clk_en,
   output logic [NCH-1:0]        irq_done
);
   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (NCH < 1 || BASE_ADDR + NCH > ADDR_SPAN) begin : g_bad_map
         $error("dma_arm_ctrl: channels do not fit the address space");
      end
      if (SRC_W < 1) begin : g_bad_src
         $error("dma_arm_ctrl: SRC_W must be at least 1");
      end
      if (TRIG_EDGE != 0 && TRIG_EDGE != 1) begin : g_bad_edge
         $error("dma_arm_ctrl: TRIG_EDGE must be 0 or 1");
      end
   endgenerate

   logic [NCH-1:0] en_vec;
   logic [NCH-1:0] pend_vec;

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         chan_wr_t req;
         logic     trig;

         dma_arm_wrdec #(.ADDR_W(ADDR_W), .MY_ADDR(BASE_ADDR + i)) u_wrdec (
            .wr_en(wr_en), .wr_addr(wr_addr), .wr_bitmode(wr_bitmode),
            .wr_bitsel(wr_bitsel), .wr_bitval(wr_bitval), .wr_data(wr_data),
            .req(req)
         );

         dma_arm_trigq #(.SRC_W(SRC_W), .TRIG_EDGE(TRIG_EDGE)) u_trigq (
            .clk(clk), .rst_n(rst_n), .sw_trig(sw_trig[i]), .hw_trig(hw_trig),
            .src_sel(src_sel[i*SRC_W +: SRC_W]), .trig(trig)
         );

         dma_arm_chan u_chan (
            .clk(clk), .rst_n(rst_n), .req(req), .trig(trig), .done(eng_done[i]),
            .en(en_vec[i]), .pend(pend_vec[i]), .start(eng_start[i]),
            .abort(eng_abort[i]), .irq(irq_done[i])
         );
      end
   endgenerate

   assign clk_en = en_vec;

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NCH; i++) begin
         if (rd_addr == ADDR_W'(BASE_ADDR + i)) begin
            rd_data[EN_BIT]   = en_vec[i];
            rd_data[PEND_BIT] = pend_vec[i];
         end
      end
   end
endmodule

// File: rtl/dma_arm_ctrl_chk.sv
module dma_arm_ctrl_chk #(
   parameter int NCH = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] en,
   input logic [NCH-1:0] pend,
   input logic [NCH-1:0] eng_start,
   input logic [NCH-1:0] eng_abort,
   input logic [NCH-1:0] irq_done
);
   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         p_start_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
            eng_start[i] |-> (en[i] && pend[i]));
         p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
            eng_start[i] |=> !eng_start[i]);
         p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
            irq_done[i] |=> !irq_done[i]);
         p_irq_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            irq_done[i] |-> !pend[i]);
         p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
            eng_abort[i] |-> (!irq_done[i] && !pend[i]));
         p_en_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(pend[i]) |-> (en[i] == $past(en[i])));
      end
   endgenerate
endmodule

bind dma_arm_ctrl dma_arm_ctrl_chk #(.NCH(NCH)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en_vec), .pend(pend_vec),
   .eng_start(eng_start), .eng_abort(eng_abort), .irq_done(irq_done)
);

// File: tb/dma_arm_ctrl_bench.sv
`timescale 1ns/1ps
module dma_arm_ctrl_bench;
   localparam int NCH = 2, ADDR_W = 4, BASE = 12, SRC_W = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0, wr_bitmode = 1'b0, wr_bitval = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
   logic [2:0] wr_bitsel = '0;
   logic [7:0] wr_data = '0, rd_data;
   logic [NCH-1:0] sw_trig = '0, eng_done = '0;
   logic [7:0] hw_trig = '0;
   logic [NCH*SRC_W-1:0] src_sel = '0;
   logic [NCH-1:0] eng_start, eng_abort, clk_en, irq_done;

   int vectors = 0, fails = 0;
   int exp_q[$];   // expected pulses: ch*4 + kind (0 start, 1 abort, 2 irq)

   dma_arm_ctrl u_dma_arm_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_bitmode(wr_bitmode), .wr_bitsel(wr_bitsel), .wr_bitval(wr_bitval),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .sw_trig(sw_trig), .hw_trig(hw_trig), .src_sel(src_sel),
      .eng_start(eng_start), .eng_abort(eng_abort), .eng_done(eng_done),
      .clk_en(clk_en), .irq_done(irq_done)
   );

   always #4 clk = ~clk;

   function automatic string ktag(int k);
      return (k == 0) ? "R6" : (k == 1) ? "R8" : "R7";
   endfunction

   // monitor: compares every strobe against the scoreboard queue
   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < 3; k++) begin
               logic p;
               int   e;
               p = (k == 0) ? eng_start[c] : (k == 1) ? eng_abort[c] : irq_done[c];
               if (p) begin
                  vectors++;
                  if (exp_q.size() == 0) begin
                     fails++;
                     $display("FAIL %s unexpected pulse: actual ch%0d kind %0d, expected none",
                              ktag(k), c, k);
                  end else begin
                     e = exp_q.pop_front();
                     if (e != c*4 + k) begin
                        fails++;
                        $display("FAIL %s pulse mismatch: actual %0d, expected %0d",
                                 ktag(k), c*4 + k, e);
                     end
                  end
               end
            end
         end
      end
   end

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic rd(int ch, logic [7:0] exp, string tag);
      @(negedge clk);
      rd_addr = ADDR_W'(BASE + ch);
      #1 chk(tag, rd_data, exp);
   endtask

   task automatic wr_byte(int ch, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_bitmode = 1'b0; wr_addr = ADDR_W'(BASE + ch); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr_bit(int ch, int pos, logic v);
      @(negedge clk);
      wr_en = 1'b1; wr_bitmode = 1'b1; wr_addr = ADDR_W'(BASE + ch);
      wr_bitsel = 3'(pos); wr_bitval = v;
      @(negedge clk);
      wr_en = 1'b0; wr_bitmode = 1'b0;
   endtask

   task automatic pulse_sw(int ch);
      @(negedge clk); sw_trig[ch] = 1'b1;
      @(negedge clk); sw_trig = '0;
   endtask

   task automatic pulse_hw(int src);
      @(negedge clk); hw_trig[src] = 1'b1;
      @(negedge clk); hw_trig = '0;
   endtask

   task automatic done(int ch);
      @(negedge clk); eng_done[ch] = 1'b1;
      @(negedge clk); eng_done = '0;
   endtask

   task automatic finish_run();
      repeat (3) @(negedge clk);
      while (exp_q.size() != 0) begin
         int e;
         e = exp_q.pop_front();
         vectors++; fails++;
         $display("FAIL %s missing pulse: actual none, expected %0d", ktag(e % 4), e);
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R2: reset state
      rd(0, 8'h00, "R2 ch0 reset");
      rd(1, 8'h00, "R2 ch1 reset");
      chk("R2 clk_en reset", {6'b0, clk_en}, 8'h00);
      rst_n = 1'b1;
      rd(0, 8'h00, "R2 ch0 after release");

      // R1 / R3: byte write, unused bits read 0
      wr_byte(0, 8'h81);
      rd(0, 8'h81, "R3 byte write");
      wr_byte(0, 8'hFF);
      rd(0, 8'h81, "R1 bits 6..1 read 0");
      @(negedge clk); rd_addr = 4'h3;
      #1 chk("R1 unmapped read", rd_data, 8'h00);
      chk("R9 clk_en ch0 on", {6'b0, clk_en}, 8'h01);

      // R6: only the selected hardware source starts ch0
      src_sel[2:0] = 3'd5;
      pulse_hw(3);                 // R6 unselected line: no pulse expected
      exp_q.push_back(0*4 + 0);
      pulse_hw(5);                 // R6 selected line starts
      pulse_sw(0);                 // R11 busy: trigger ignored
      exp_q.push_back(0*4 + 2);
      done(0);                     // R7 completion
      rd(0, 8'h80, "R7 pending cleared by done");

      // R4: enable locked while pending
      wr_byte(0, 8'h81);
      wr_byte(0, 8'h01);
      rd(0, 8'h81, "R4 byte write cannot clear enable");
      wr_bit(0, 7, 1'b0);
      rd(0, 8'h81, "R4 bit write cannot clear enable");
      wr_bit(0, 3, 1'b1);
      rd(0, 8'h81, "R3 bit write to unused bit ignored");

      // R8: forced termination
      exp_q.push_back(0*4 + 0);
      pulse_sw(0);                 // R6 software start
      exp_q.push_back(0*4 + 1);
      wr_bit(0, 0, 1'b0);
      rd(0, 8'h80, "R8 pending cleared by abort");
      done(0);                     // late done after abort: ignored
      wr_bit(0, 7, 1'b0);
      rd(0, 8'h00, "R9 enable cleared");
      chk("R9 clk_en ch0 off", {6'b0, clk_en}, 8'h00);

      // R5: pending without enable drops triggers
      wr_bit(0, 0, 1'b1);
      rd(0, 8'h01, "R3 bit write sets pending");
      pulse_sw(0);                 // R5 dropped
      pulse_hw(5);                 // R5 dropped
      wr_byte(0, 8'h00);           // R8 clear with no transfer: no abort
      rd(0, 8'h00, "R8 idle clear");

      // R10: channel 1 independent
      src_sel[5:3] = 3'd2;
      wr_byte(1, 8'h81);
      rd(1, 8'h81, "R10 ch1 written");
      rd(0, 8'h00, "R10 ch0 untouched");
      chk("R9 clk_en ch1 only", {6'b0, clk_en}, 8'h02);
      exp_q.push_back(1*4 + 0);
      pulse_hw(2);

      // R12: write clearing pending collides with done
      exp_q.push_back(1*4 + 2);
      @(negedge clk);
      wr_en = 1'b1; wr_bitmode = 1'b0; wr_addr = ADDR_W'(BASE + 1); wr_data = 8'h80;
      eng_done[1] = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; eng_done = '0;
      rd(1, 8'h80, "R12 collision leaves pending 0");

      finish_run();
   end
endmodule